// File: doc/BRIEF.md
# I2C Master Byte Staging Buffer

This block is a small byte store placed between a host register port and an I2C master transfer engine. The host pushes bytes and pops them one at a time. Each pop returns the oldest byte, and all later bytes move one slot toward the head. The transfer engine can overwrite the whole buffer in one cycle with the bytes it has received, and the fill level follows. Two registered status outputs report whether any byte is held and whether all slots are taken. A flush input discards everything.

The block does no bus signalling and no register decode. The surrounding controller turns its register accesses into single-cycle `push_en` and `pop_en` strobes, and routes engine results through the load port. A pop of an empty buffer returns all ones. The popped byte appears on `pop_data` one clock after the pop strobe and is held until the next accepted pop.

Top module: `xfer_byte_buf`

## Requirements
- R1: The buffer holds DEPTH (default 4) bytes of WIDTH (default 8) bits and returns them in the order they were pushed.
- R2: A push while all DEPTH slots are taken, with no pop in the same cycle, is ignored: the contents, `has_data` and `full` are unchanged.
- R3: `has_data` rises in the cycle after a byte enters an empty buffer. `full` rises in the cycle after the slot count reaches DEPTH. `full` never stands without `has_data`.
- R4: A pop of an empty buffer puts 0xFF (all ones) on `pop_data` one cycle later and changes neither the contents nor the flags.
- R5: A pop of a non-empty buffer puts the head byte on `pop_data` one cycle later and moves every remaining byte one slot toward the head. `pop_data` holds its value until the next accepted pop.
- R6: A pop from a full buffer lowers `full` in the next cycle. A pop that removes the last byte lowers `has_data` in the next cycle.
- R7: `flush` empties the buffer, zeroes every slot and lowers both flags in the next cycle. It overrides load, push and pop in the same cycle. `pop_data` is left unchanged.
- R8: A synchronous active-high `rst` empties the buffer, zeroes every slot, lowers both flags and sets `pop_data` to all ones.
- R9: When push and pop are asserted together, the pop is taken first and then the push. On a full buffer, both take effect and `full` stays high. On an empty buffer, `pop_data` becomes 0xFF and the pushed byte is stored.
- R10: `load_en` writes the first N bytes of `load_data` into slots 0 to N-1 and sets the count to N. Here N is `load_count`, limited to DEPTH. Byte k of `load_data` is bits [8k+7:8k]. Slots at N and above are zeroed. Push and pop in the same cycle are ignored, and the flags follow N in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Host byte write strobe |
| push_data | input | 8 | Byte to push |
| pop_en | input | 1 | Host byte read strobe |
| pop_data | output | 8 | Registered byte from the last accepted pop |
| load_en | input | 1 | Engine bulk load strobe |
| load_count | input | 3 | Number of bytes to load (values above DEPTH are limited to DEPTH) |
| load_data | input | 32 | Bytes to load, byte k in bits [8k+7:8k] |
| flush | input | 1 | Empty and clear the buffer |
| has_data | output | 1 | At least one byte held |
| full | output | 1 | All slots taken |

## Verification
At every fill level from empty to full, the bench applies each combination of push and pop. This separates the ignored push at full, the all-ones read when empty, and the pop-then-push order at both ends. A bulk load with every count from zero to above DEPTH, followed by pops until the buffer is dry, shows that each byte lane lands in its own slot and that the count is limited. Cycles that combine flush, load and the host strobes check the override order. A long pseudo-random mix of all operations is then compared against a queue model in the bench.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  parameter int XBB_DEPTH = 4;
  parameter int XBB_WIDTH = 8;

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/xbb_level.sv
module xbb_level #(
  parameter int DEPTH = xbb_pkg::XBB_DEPTH,
  parameter int CW    = xbb_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          load_en,
  input  logic [CW-1:0] load_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] push_pos,
  output logic [CW-1:0] cnt,
  output logic          has_data,
  output logic          full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic          host_cyc;
  logic [CW-1:0] cnt_nxt;

  // Pop is resolved first; the push lands at the level left after it.
  always_comb begin
    host_cyc = !flush && !load_en;
    pop_ok   = host_cyc && pop_req && (cnt != '0);
    push_pos = cnt - CW'(pop_ok);
    push_ok  = host_cyc && push_req && (push_pos != CNT_MAX);
    if (flush)        cnt_nxt = '0;
    else if (load_en) cnt_nxt = load_n;
    else              cnt_nxt = push_pos + CW'(push_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      has_data <= (cnt_nxt != '0);
      full     <= (cnt_nxt == CNT_MAX);
    end
  end
endmodule

// File: rtl/xbb_store.sv
module xbb_store #(
  parameter int DEPTH = xbb_pkg::XBB_DEPTH,
  parameter int W     = xbb_pkg::XBB_WIDTH,
  parameter int CW    = xbb_pkg::cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load_en,
  input  logic [CW-1:0]    load_n,
  input  logic [DEPTH*W-1:0] load_data,
  input  logic             pop_ok,
  input  logic             push_ok,
  input  logic [CW-1:0]    push_pos,
  input  logic [W-1:0]     push_data,
  output logic [W-1:0]     head
);
  logic [W-1:0] slot [DEPTH];

  assign head = slot[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [CW-1:0] IDX = CW'(i);
    logic [W-1:0] above;
    logic [W-1:0] nxt;

    if (i == DEPTH - 1) begin : g_top
      assign above = '0;
    end else begin : g_mid
      assign above = slot[i+1];
    end

    always_comb begin
      nxt = pop_ok ? above : slot[i];
      if (push_ok && (push_pos == IDX)) nxt = push_data;
    end

    always_ff @(posedge clk) begin
      if (rst || flush)  slot[i] <= '0;
      else if (load_en)  slot[i] <= (IDX < load_n) ? load_data[i*W +: W] : '0;
      else               slot[i] <= nxt;
    end
  end
endmodule

// File: rtl/xfer_byte_buf.sv
module xfer_byte_buf #(
  parameter int DEPTH = xbb_pkg::XBB_DEPTH,
  parameter int W     = xbb_pkg::XBB_WIDTH,
  parameter int CW    = xbb_pkg::cnt_bits(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_en,
  input  logic [W-1:0]       push_data,
  input  logic               pop_en,
  output logic [W-1:0]       pop_data,
  input  logic               load_en,
  input  logic [CW-1:0]      load_count,
  input  logic [DEPTH*W-1:0] load_data,
  input  logic               flush,
  output logic               has_data,
  output logic               full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [CW-1:0] load_n;
  logic [CW-1:0] push_pos;
  logic [CW-1:0] cnt;
  logic          push_ok;
  logic          pop_ok;
  logic [W-1:0]  head;

  assign load_n = (load_count > CNT_MAX) ? CNT_MAX : load_count;

  xbb_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst(rst), .flush(flush), .load_en(load_en), .load_n(load_n),
    .push_req(push_en), .pop_req(pop_en), .push_ok(push_ok), .pop_ok(pop_ok),
    .push_pos(push_pos), .cnt(cnt), .has_data(has_data), .full(full)
  );

  xbb_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .load_en(load_en), .load_n(load_n),
    .load_data(load_data), .pop_ok(pop_ok), .push_ok(push_ok),
    .push_pos(push_pos), .push_data(push_data), .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pop_data <= '1;
    else if (pop_en && !flush && !load_en)
      pop_data <= (cnt == '0) ? '1 : head;
  end
endmodule

// File: rtl/xbb_checker.sv
module xbb_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         push_en,
  input logic         pop_en,
  input logic         load_en,
  input logic         flush,
  input logic         has_data,
  input logic         full,
  input logic [W-1:0] pop_data
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!has_data && !full && pop_data == '1)); // R8

  AST_FULL_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    full |-> has_data); // R3

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!has_data && push_en && !flush && !load_en) |=> has_data); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push_en && !pop_en && !flush && !load_en) |=> full); // R2

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (!has_data && pop_en && !flush && !load_en) |=> (pop_data == '1)); // R4

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && pop_en && !push_en && !flush && !load_en) |=> !full); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!has_data && !full && $stable(pop_data))); // R7

  AST_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pop_en && !$past(rst)) |=> $stable(pop_data)); // R5
endmodule

bind xfer_byte_buf xbb_checker u_chk (
  .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
  .load_en(load_en), .flush(flush), .has_data(has_data), .full(full),
  .pop_data(pop_data)
);

// File: tb/tb_xfer_byte_buf.sv
`timescale 1ns/1ps
module tb_xfer_byte_buf;
  localparam int D  = 4;
  localparam int W  = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst = 1'b1;
  logic           push_en = 1'b0, pop_en = 1'b0, load_en = 1'b0, flush = 1'b0;
  logic [W-1:0]   push_data = '0;
  logic [CW-1:0]  load_count = '0;
  logic [D*W-1:0] load_data = '0;
  logic [W-1:0]   pop_data;
  logic           has_data, full;

  xfer_byte_buf dut (
    .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .pop_data(pop_data), .load_en(load_en),
    .load_count(load_count), .load_data(load_data), .flush(flush),
    .has_data(has_data), .full(full)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] exp_pd = 8'hFF;
  logic [15:0]  lf = 16'hACE1;

  task automatic chk(input string tag);
    n_chk++;
    if (has_data !== (q.size() != 0) || full !== (q.size() == D) || pop_data !== exp_pd) begin
      n_fail++;
      $display("FAIL %s: actual has=%0b full=%0b pd=%02h expected has=%0b full=%0b pd=%02h",
               tag, has_data, full, pop_data, q.size() != 0, q.size() == D, exp_pd);
    end
  endtask

  task automatic step(input string tag, input logic ps, input logic [W-1:0] d,
                      input logic pp, input logic fl, input logic lo,
                      input logic [CW-1:0] n, input logic [D*W-1:0] ldat);
    @(negedge clk);
    push_en = ps; push_data = d; pop_en = pp; flush = fl;
    load_en = lo; load_count = n; load_data = ldat;
    @(posedge clk);
    if (fl) q.delete();
    else if (lo) begin
      q.delete();
      for (int k = 0; k < ((n > D) ? D : n); k++) q.push_back(ldat[k*W +: W]);
    end else begin
      if (pp) exp_pd = (q.size() != 0) ? q.pop_front() : 8'hFF;
      if (ps && q.size() < D) q.push_back(d);
    end
    @(negedge clk);
    push_en = 0; pop_en = 0; flush = 0; load_en = 0;
    chk(tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R8 reset state");

    // every fill level against every push/pop combination
    for (int lvl = 0; lvl <= D; lvl++) begin
      for (int c = 0; c < 4; c++) begin
        step("R7 flush", 0, 0, 0, 1, 0, 0, 0);
        for (int k = 0; k < lvl; k++)
          step("R3 fill", 1, W'(8'h10 * lvl + k + 1), 0, 0, 0, 0, 0);
        step(c == 3 ? "R9 push+pop" : (c == 1 ? "R2 push" : "R4 pop"),
             c[0], W'(8'hA0 + c), c[1], 0, 0, 0, 0);
        for (int k = 0; k <= D; k++)
          step("R6 drain", 0, 0, 1, 0, 0, 0, 0);
      end
    end

    // bulk load with every count, including beyond DEPTH
    for (int n = 0; n <= 7; n++) begin
      step("R10 load", 1, 8'h55, 1, 0, 1, CW'(n), 32'hD4C3B2A1 + n);
      for (int k = 0; k <= D; k++)
        step("R5 pop after load", 0, 0, 1, 0, 0, 0, 0);
    end

    // override order
    step("R3 push", 1, 8'h11, 0, 0, 0, 0, 0);
    step("R7 flush over load", 1, 8'h22, 1, 1, 1, 3'd2, 32'h01020304);
    step("R10 load", 0, 0, 0, 0, 1, 3'd4, 32'h44332211);
    step("R9 full push+pop", 1, 8'h99, 1, 0, 0, 0, 0);
    step("R1 order", 0, 0, 1, 0, 0, 0, 0);

    // mid-run reset
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    q.delete(); exp_pd = 8'hFF;
    chk("R8 reset mid-run");

    // pseudo-random mix against the queue model
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R1 random", lf[4], lf[15:8], lf[5], lf[3:0] == 4'd0, lf[3:0] == 4'd1,
           lf[7:5], {lf, ~lf});
    end

    summary();
  end
endmodule